// File: doc/BRIEF.md
# Bridge Address Parity Error Handler

This block watches the address phases on both buses of a two-port PCI-to-PCI bridge and checks their parity. The check covers every bus command. When an address parity error is found, the block decides whether the side that saw it must hold back its target claim, and it sets sticky error flags for the status registers. If the controls allow it, the block also pulses the active-low system error output on the primary bus. An error on either bus is reported on that one primary output.

Each side has its own small state machine, with states ST_IDLE, ST_PAR_SINGLE, ST_PAR_FIRST and ST_PAR_SECOND. From ST_IDLE, a sampled address strobe moves it to ST_PAR_SINGLE, or to ST_PAR_FIRST when the dual-address flag is high. In ST_PAR_SINGLE and ST_PAR_SECOND the machine compares the incoming parity bit and then returns to ST_IDLE. ST_PAR_FIRST compares the first parity bit, latches the second address phase and moves on to ST_PAR_SECOND. The response bit that gates claim suppression and error reporting comes from a different register on each side: the primary side uses the command register and the secondary side uses the bridge control register. The system error enable always comes from the command register.

Top module: `bridge_apar_top`

## Requirements
- R1: Parity is even. The XOR of all 32 AD bits, the 4 C/BE bits and PAR must be 0. PAR is the value on the parity pin in the clock after the address phase it covers. The check is made whatever the command code on C/BE.
- R2: The result of a check appears on the registered outputs at the clock edge that ends the cycle in which PAR is present. Parity seen outside an address check is ignored.
- R3: A primary error drives `pri_claim_inhibit` high for exactly one cycle when `cmd_perr_rsp` is 1. When `cmd_perr_rsp` is 0, `pri_claim_inhibit` stays low.
- R4: A secondary error drives `sec_claim_inhibit` high for one cycle when `bctl_perr_rsp` is 1, whatever `cmd_perr_rsp` is. When `bctl_perr_rsp` is 0, `sec_claim_inhibit` stays low.
- R5: A primary error sets `pri_dpe` whatever the control inputs are. The bit stays set until `pri_dpe_clr` is high at a clock edge with no new primary error at that same edge.
- R6: A secondary error sets `sec_dpe` under the same sticky rule, using `sec_dpe_clr`.
- R7: A primary error drives `pri_serr_n` low for one cycle only when `cmd_serr_en`, `cmd_perr_rsp` are both 1 and `serr_mask_pri` is 0.
- R8: A secondary error drives `pri_serr_n` low for one cycle only when `cmd_serr_en`, `bctl_perr_rsp` are both 1 and `serr_mask_sec` is 0.
- R9: `pri_sse` is set whenever `pri_serr_n` is driven low. It stays set until `pri_sse_clr` is high at an edge with no new report. A new report at the same edge as a clear wins.
- R10: In a dual-address cycle (dual flag high with the strobe), both address phases are checked. A bad first phase, a bad second phase or both bad produce one single error, reported at the edge after the second PAR.
- R11: Reset drives all flags and both inhibits to 0 and `pri_serr_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pri_addr_vld | input | 1 | Primary address phase strobe |
| pri_dual_addr | input | 1 | Primary address phase starts a dual-address cycle |
| pri_ad | input | 32 | Primary address/data lines |
| pri_cbe | input | 4 | Primary command/byte-enable lines |
| pri_par | input | 1 | Primary parity pin |
| sec_addr_vld | input | 1 | Secondary address phase strobe |
| sec_dual_addr | input | 1 | Secondary address phase starts a dual-address cycle |
| sec_ad | input | 32 | Secondary address/data lines |
| sec_cbe | input | 4 | Secondary command/byte-enable lines |
| sec_par | input | 1 | Secondary parity pin |
| cmd_perr_rsp | input | 1 | Parity response bit, command register |
| cmd_serr_en | input | 1 | System error enable, command register |
| bctl_perr_rsp | input | 1 | Parity response bit, bridge control register |
| serr_mask_pri | input | 1 | Masks system error for primary address errors |
| serr_mask_sec | input | 1 | Masks system error for secondary address errors |
| pri_dpe_clr | input | 1 | Write-one-to-clear strobe for pri_dpe |
| sec_dpe_clr | input | 1 | Write-one-to-clear strobe for sec_dpe |
| pri_sse_clr | input | 1 | Write-one-to-clear strobe for pri_sse |
| pri_claim_inhibit | output | 1 | Holds back the primary target claim |
| sec_claim_inhibit | output | 1 | Holds back the secondary target claim |
| pri_dpe | output | 1 | Primary detected parity error flag |
| sec_dpe | output | 1 | Secondary detected parity error flag |
| pri_sse | output | 1 | Signaled system error flag |
| pri_serr_n | output | 1 | Primary system error output, active low |

## Verification
The assertions assume that on each side the address strobe is raised only while that side's machine is idle. After a single address phase the next strobe comes no sooner than two cycles later, and after a dual-address cycle no sooner than three cycles later, as the bus protocol guarantees. Under that spacing a claim inhibit can never last two cycles. The bench's transaction task follows the spacing: after each parity cycle it leaves at least one idle cycle filled with random data and random parity before the next strobe. Control changes and clear strobes are the only stimulus allowed to land on any cycle.

// File: rtl/apar_pkg.sv
package apar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PAR_SINGLE = 2'd1,
        ST_PAR_FIRST  = 2'd2,
        ST_PAR_SECOND = 2'd3
    } apar_state_e;

    localparam int NSIDE    = 2;
    localparam int SIDE_PRI = 0;
    localparam int SIDE_SEC = 1;

endpackage

// File: rtl/apar_side_fsm.sv
module apar_side_fsm
    import apar_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_vld,
    input  logic             dual_addr,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    input  logic             par,
    output logic             ape
);

    apar_state_e state_q, state_d;
    logic        exp_q, exp_d;
    logic        first_bad_q, first_bad_d;
    logic        phase_xor;

    assign phase_xor = ^{ad, cbe};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            exp_q       <= 1'b0;
            first_bad_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            exp_q       <= exp_d;
            first_bad_q <= first_bad_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        exp_d       = exp_q;
        first_bad_d = first_bad_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_vld) begin
                    exp_d       = phase_xor;
                    first_bad_d = 1'b0;
                    state_d     = dual_addr ? ST_PAR_FIRST : ST_PAR_SINGLE;
                end
            end
            ST_PAR_SINGLE: state_d = ST_IDLE;
            ST_PAR_FIRST: begin
                first_bad_d = par ^ exp_q;
                exp_d       = phase_xor;
                state_d     = ST_PAR_SECOND;
            end
            ST_PAR_SECOND: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ape = 1'b0;
        unique case (state_q)
            ST_PAR_SINGLE: ape = par ^ exp_q;
            ST_PAR_SECOND: ape = first_bad_q | (par ^ exp_q);
            default:       ape = 1'b0;
        endcase
    end

endmodule

// File: rtl/apar_sticky.sv
module apar_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set | (q & ~clr);
    end

endmodule

// File: rtl/bridge_apar_top.sv
module bridge_apar_top
    import apar_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pri_addr_vld,
    input  logic             pri_dual_addr,
    input  logic [AD_W-1:0]  pri_ad,
    input  logic [CBE_W-1:0] pri_cbe,
    input  logic             pri_par,
    input  logic             sec_addr_vld,
    input  logic             sec_dual_addr,
    input  logic [AD_W-1:0]  sec_ad,
    input  logic [CBE_W-1:0] sec_cbe,
    input  logic             sec_par,
    input  logic             cmd_perr_rsp,
    input  logic             cmd_serr_en,
    input  logic             bctl_perr_rsp,
    input  logic             serr_mask_pri,
    input  logic             serr_mask_sec,
    input  logic             pri_dpe_clr,
    input  logic             sec_dpe_clr,
    input  logic             pri_sse_clr,
    output logic             pri_claim_inhibit,
    output logic             sec_claim_inhibit,
    output logic             pri_dpe,
    output logic             sec_dpe,
    output logic             pri_sse,
    output logic             pri_serr_n
);

    logic [NSIDE-1:0] side_vld, side_dual, side_par, side_ape;
    logic [NSIDE-1:0] side_rsp, side_mask, side_clr, side_dpe, side_report;
    logic [AD_W-1:0]  side_ad  [NSIDE];
    logic [CBE_W-1:0] side_cbe [NSIDE];
    logic [NSIDE-1:0] inhibit_q;
    logic             serr_n_q;

    assign side_vld  = {sec_addr_vld, pri_addr_vld};
    assign side_dual = {sec_dual_addr, pri_dual_addr};
    assign side_par  = {sec_par, pri_par};
    assign side_rsp  = {bctl_perr_rsp, cmd_perr_rsp};
    assign side_mask = {serr_mask_sec, serr_mask_pri};
    assign side_clr  = {sec_dpe_clr, pri_dpe_clr};
    assign side_ad[SIDE_PRI]  = pri_ad;
    assign side_ad[SIDE_SEC]  = sec_ad;
    assign side_cbe[SIDE_PRI] = pri_cbe;
    assign side_cbe[SIDE_SEC] = sec_cbe;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        apar_side_fsm #(.AD_W(AD_W), .CBE_W(CBE_W)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .addr_vld  (side_vld[g]),
            .dual_addr (side_dual[g]),
            .ad        (side_ad[g]),
            .cbe       (side_cbe[g]),
            .par       (side_par[g]),
            .ape       (side_ape[g])
        );

        assign side_report[g] = side_ape[g] & cmd_serr_en & side_rsp[g] & ~side_mask[g];

        apar_sticky u_dpe (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (side_ape[g]),
            .clr   (side_clr[g]),
            .q     (side_dpe[g])
        );
    end

    apar_sticky u_sse (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (|side_report),
        .clr   (pri_sse_clr),
        .q     (pri_sse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inhibit_q <= '0;
            serr_n_q  <= 1'b1;
        end else begin
            inhibit_q <= side_ape & side_rsp;
            serr_n_q  <= ~(|side_report);
        end
    end

    assign pri_claim_inhibit = inhibit_q[SIDE_PRI];
    assign sec_claim_inhibit = inhibit_q[SIDE_SEC];
    assign pri_dpe           = side_dpe[SIDE_PRI];
    assign sec_dpe           = side_dpe[SIDE_SEC];
    assign pri_serr_n        = serr_n_q;

endmodule

// File: rtl/apar_checker.sv
module apar_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_serr_en,
    input logic pri_dpe_clr,
    input logic sec_dpe_clr,
    input logic pri_claim_inhibit,
    input logic sec_claim_inhibit,
    input logic pri_dpe,
    input logic sec_dpe,
    input logic pri_sse,
    input logic pri_serr_n
);

    AST_PRI_INH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        pri_claim_inhibit |-> pri_dpe); // R3
    AST_PRI_INH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pri_claim_inhibit |=> !pri_claim_inhibit); // R3
    AST_SEC_INH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        sec_claim_inhibit |-> sec_dpe); // R4
    AST_PRI_DPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_dpe && !pri_dpe_clr) |=> pri_dpe); // R5
    AST_SEC_DPE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_dpe && !sec_dpe_clr) |=> sec_dpe); // R6
    AST_SERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_serr_n |-> $past(cmd_serr_en)); // R7
    AST_SERR_FLAGS_SSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_serr_n |-> pri_sse); // R9

endmodule

bind bridge_apar_top apar_checker u_apar_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmd_serr_en       (cmd_serr_en),
    .pri_dpe_clr       (pri_dpe_clr),
    .sec_dpe_clr       (sec_dpe_clr),
    .pri_claim_inhibit (pri_claim_inhibit),
    .sec_claim_inhibit (sec_claim_inhibit),
    .pri_dpe           (pri_dpe),
    .sec_dpe           (sec_dpe),
    .pri_sse           (pri_sse),
    .pri_serr_n        (pri_serr_n)
);

// File: tb/sim_bridge_apar_top.sv
module sim_bridge_apar_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_b  [2];
    logic        dual_b [2];
    logic [31:0] ad_b   [2];
    logic [3:0]  cbe_b  [2];
    logic        par_b  [2];
    logic        dpe_clr_b [2];
    logic        cmd_perr_rsp, cmd_serr_en, bctl_perr_rsp;
    logic        serr_mask_pri, serr_mask_sec, pri_sse_clr;
    logic        pri_claim_inhibit, sec_claim_inhibit, pri_dpe, sec_dpe, pri_sse, pri_serr_n;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    bit          m_due[2], m_last[2], m_exp[2], m_acc[2], m_second[2];
    bit          e_inh[2], e_dpe[2];
    bit          e_sse, e_serr_n = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    bridge_apar_top u0 (
        .clk(clk), .rst_n(rst_n),
        .pri_addr_vld(vld_b[0]), .pri_dual_addr(dual_b[0]), .pri_ad(ad_b[0]),
        .pri_cbe(cbe_b[0]), .pri_par(par_b[0]),
        .sec_addr_vld(vld_b[1]), .sec_dual_addr(dual_b[1]), .sec_ad(ad_b[1]),
        .sec_cbe(cbe_b[1]), .sec_par(par_b[1]),
        .cmd_perr_rsp(cmd_perr_rsp), .cmd_serr_en(cmd_serr_en),
        .bctl_perr_rsp(bctl_perr_rsp),
        .serr_mask_pri(serr_mask_pri), .serr_mask_sec(serr_mask_sec),
        .pri_dpe_clr(dpe_clr_b[0]), .sec_dpe_clr(dpe_clr_b[1]), .pri_sse_clr(pri_sse_clr),
        .pri_claim_inhibit(pri_claim_inhibit), .sec_claim_inhibit(sec_claim_inhibit),
        .pri_dpe(pri_dpe), .sec_dpe(sec_dpe), .pri_sse(pri_sse), .pri_serr_n(pri_serr_n)
    );

    // Reference model: a queue of pending parity checks per side (R1, R2, R10)
    always @(posedge clk) begin
        bit err[2];
        bit rsp[2];
        bit msk[2];
        bit report;
        rsp[0] = cmd_perr_rsp;  rsp[1] = bctl_perr_rsp;
        msk[0] = serr_mask_pri; msk[1] = serr_mask_sec;
        if (!rst_n) begin
            for (int s = 0; s < 2; s++) begin
                m_due[s] = 0; m_last[s] = 0; m_exp[s] = 0; m_acc[s] = 0; m_second[s] = 0;
                e_inh[s] = 0; e_dpe[s] = 0;
            end
            e_sse = 0; e_serr_n = 1;
        end else begin
            report = 0;
            for (int s = 0; s < 2; s++) begin
                bit miss;
                err[s] = 0;
                if (m_due[s]) begin
                    miss = par_b[s] ^ m_exp[s];
                    if (m_last[s]) begin
                        err[s] = m_acc[s] | miss;
                        m_acc[s] = 0;
                    end else begin
                        m_acc[s] = miss;
                    end
                end
                if (m_second[s]) begin
                    m_exp[s] = ^{ad_b[s], cbe_b[s]};
                    m_due[s] = 1; m_last[s] = 1; m_second[s] = 0;
                end else if (vld_b[s] && !m_due[s]) begin
                    m_exp[s] = ^{ad_b[s], cbe_b[s]};
                    m_due[s] = 1; m_last[s] = !dual_b[s]; m_second[s] = dual_b[s];
                    m_acc[s] = 0;
                end else begin
                    m_due[s] = 0;
                end
                e_inh[s] = err[s] & rsp[s];
                e_dpe[s] = err[s] | (e_dpe[s] & ~dpe_clr_b[s]);
                if (err[s] && cmd_serr_en && rsp[s] && !msk[s]) report = 1;
            end
            e_serr_n = !report;
            e_sse    = report | (e_sse & ~pri_sse_clr);
        end
    end

    task automatic check1(input string tag, input string nm, input logic act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: actual %b expected %b", tag, nm, $time, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        check1("R3", "pri_claim_inhibit", pri_claim_inhibit, e_inh[0]);
        check1("R4", "sec_claim_inhibit", sec_claim_inhibit, e_inh[1]);
        check1("R5", "pri_dpe", pri_dpe, e_dpe[0]);
        check1("R6", "sec_dpe", sec_dpe, e_dpe[1]);
        check1("R7", "pri_serr_n", pri_serr_n, e_serr_n);
        check1("R9", "pri_sse", pri_sse, e_sse);
    end

    task automatic txn(input int s, input bit dual, input bit bad1, input bit bad2);
        bit p;
        @(negedge clk);
        vld_b[s] = 1; dual_b[s] = dual; ad_b[s] = $urandom; cbe_b[s] = 4'($urandom);
        @(negedge clk);
        vld_b[s] = 0; dual_b[s] = 0;
        p = (^{ad_b[s], cbe_b[s]}) ^ bad1;
        par_b[s] = p;
        ad_b[s] = $urandom; cbe_b[s] = 4'($urandom);
        if (dual) begin
            @(negedge clk);
            par_b[s] = (^{ad_b[s], cbe_b[s]}) ^ bad2;
            ad_b[s] = $urandom; cbe_b[s] = 4'($urandom);
        end
        @(negedge clk);
        par_b[s] = 1'($urandom); ad_b[s] = $urandom; cbe_b[s] = 4'($urandom);
    endtask

    task automatic set_ctl(input bit c_rsp, input bit c_en, input bit b_rsp,
                           input bit m_p, input bit m_s);
        @(negedge clk);
        cmd_perr_rsp = c_rsp; cmd_serr_en = c_en; bctl_perr_rsp = b_rsp;
        serr_mask_pri = m_p; serr_mask_sec = m_s;
    endtask

    task automatic clear_all();
        @(negedge clk);
        dpe_clr_b[0] = 1; dpe_clr_b[1] = 1; pri_sse_clr = 1;
        @(negedge clk);
        dpe_clr_b[0] = 0; dpe_clr_b[1] = 0; pri_sse_clr = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R2 watchdog: actual still running expected finished");
        finish_run();
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            vld_b[s] = 0; dual_b[s] = 0; ad_b[s] = 0; cbe_b[s] = 0; par_b[s] = 0; dpe_clr_b[s] = 0;
        end
        cmd_perr_rsp = 1; cmd_serr_en = 1; bctl_perr_rsp = 1;
        serr_mask_pri = 0; serr_mask_sec = 0; pri_sse_clr = 0;
        // R11: reset state checked on every clock while reset is held
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: good parity, any command, no error
        txn(0, 0, 0, 0); txn(1, 0, 0, 0);
        // R3 R5 R7 R9: primary error with full reporting
        txn(0, 0, 1, 0);
        clear_all();
        // R3: response bit clear, flag only
        set_ctl(0, 1, 1, 0, 0);
        txn(0, 0, 1, 0);
        // R4 R8: secondary gated by bridge control bit, not command bit
        txn(1, 0, 1, 0);
        clear_all();
        set_ctl(1, 1, 0, 0, 0);
        txn(1, 0, 1, 0);
        // R7 R8: masks and enable
        set_ctl(1, 1, 1, 1, 1);
        txn(0, 0, 1, 0); txn(1, 0, 1, 0);
        set_ctl(1, 0, 1, 0, 0);
        txn(0, 0, 1, 0);
        clear_all();
        // R10: dual-address cycles, each phase pattern
        set_ctl(1, 1, 1, 0, 0);
        txn(0, 1, 0, 0); txn(0, 1, 0, 1); txn(0, 1, 1, 0); txn(0, 1, 1, 1);
        txn(1, 1, 0, 1); txn(1, 1, 1, 1);
        // both sides in the same cycle
        fork txn(0, 0, 1, 0); txn(1, 0, 1, 0); join
        // R2 R9: random traffic with clear strobes on any cycle
        for (int it = 0; it < 300; it++) begin
            set_ctl(1'($urandom), 1'($urandom), 1'($urandom),
                    ($urandom % 4) == 0, ($urandom % 4) == 0);
            fork
                txn(0, 1'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0);
                txn(1, 1'($urandom), ($urandom % 3) == 0, ($urandom % 3) == 0);
                begin
                    repeat ($urandom % 4) @(negedge clk);
                    dpe_clr_b[0] = 1'($urandom); dpe_clr_b[1] = 1'($urandom);
                    pri_sse_clr = 1'($urandom);
                    @(negedge clk);
                    dpe_clr_b[0] = 0; dpe_clr_b[1] = 0; pri_sse_clr = 0;
                end
            join
        end
        // R11: reset in the middle of activity
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule